// File: doc/BRIEF.md
# Flash Self-Programming Protection Unit

This block decides, request by request, whether the CPU may write (store-program) or read (load-program) a word of on-chip program flash while it is running. A two-bit boot-size selector splits the flash into an application section that begins at word 0 and a boot section that runs from a selectable start address up to the last word. Each section has its own two-bit sticky lock field. Software or a programming port can only clear bits in a field. A chip-erase strobe is the only way to set the bits again.

For each request the unit reports the target section and whether the address lies in the read-while-write region. A store that is allowed drives a write enable. A store that is denied produces a violation pulse one cycle later. A load that is denied returns zero instead of the flash data. The general device lock modes are deliberately not inputs of this unit, so they cannot block self-programming accesses.

Top module: `flashprot_unit`

## Requirements
- R1: `req_section` is 1 (boot) when `req_addr` is at or above the boot start address and 0 (application) otherwise. The boot start for `boot_sel` 3, 2, 1 and 0 is 0x3F00, 0x3E00, 0x3C00 and 0x3800.
- R2: `req_in_rww` is 1 exactly when `req_addr` is below 0x3800. With `boot_sel`=0 this boundary is also the end of the application section.
- R3: A lock-set command from either source replaces a field with the bitwise AND of its old value and the commanded value. A field bit that is 0 never returns to 1 without a chip erase.
- R4: When `chip_erase` is high, both fields become 2'b11 on the next edge. This holds even when lock-set commands arrive in the same cycle.
- R5: Bit 0 of a field, when 0, denies stores into that section. Bit 1, when 0, denies loads into that section from code running in the other section, as given by the section of `exec_addr`. A load within the same section is always allowed. This gives: 11 open, 10 no writes, 01 no cross reads, 00 neither.
- R6: `wr_en` is high only for a valid store that is allowed, and is then equal to `req_allow`.
- R7: A denied valid store makes `viol` high for exactly the following cycle.
- R8: A valid load that is allowed passes `rd_in` to `rd_out`. In every other case `rd_out` is all zeros.
- R9: After reset both fields read 2'b11 and `viol` is 0.
- R10: Lock-set commands from the software source and the programming source in the same cycle both take effect. The resulting field is the AND of both commanded values and the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sel | input | 2 | Boot-size selector |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store-program, 0 = load-program |
| req_addr | input | 14 | Target word address |
| exec_addr | input | 14 | Address of the code issuing the request |
| rd_in | input | 16 | Word read from the flash array |
| sw_set_valid | input | 1 | Software lock-set command |
| sw_set_app | input | 2 | Software value for the application field |
| sw_set_boot | input | 2 | Software value for the boot field |
| pg_set_valid | input | 1 | Programming-port lock-set command |
| pg_set_app | input | 2 | Port value for the application field |
| pg_set_boot | input | 2 | Port value for the boot field |
| chip_erase | input | 1 | Chip-erase strobe |
| req_allow | output | 1 | Current request is allowed |
| req_section | output | 1 | Target section, 1 = boot |
| req_in_rww | output | 1 | Target is in the read-while-write region |
| wr_en | output | 1 | Write enable to the flash array |
| rd_out | output | 16 | Read data returned to the CPU |
| viol | output | 1 | Denied-store pulse |
| lock_app | output | 2 | Application lock field |
| lock_boot | output | 2 | Boot lock field |

## Verification
Three things can fall in the same cycle: a chip erase, lock-set commands from one or both sources, and a request that is judged against the fields. The bench provokes the collision with directed cycles that raise erase and both set commands together. Random traffic also makes all three coincide now and then. In each such cycle the request must be judged against the fields as they stood before the edge. After the edge the fields must read 2'b11 whenever erase was high, and the AND of every commanded value otherwise.

// File: rtl/flashprot_pkg.sv
package flashprot_pkg;
    parameter int ADDR_W = 14;
    parameter int DATA_W = 16;
    parameter int LOCK_W = 2;
    parameter int NUM_SEC = 2;

    localparam int SEL_W = 2;
    localparam int NUM_SIZES = 1 << SEL_W;

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [LOCK_W-1:0] lockf_t;

    typedef enum logic {
        SEC_APP  = 1'b0,
        SEC_BOOT = 1'b1
    } section_e;

    // bit positions inside a lock field
    localparam int LK_WRITE = 0;
    localparam int LK_XREAD = 1;
    localparam lockf_t LOCK_OPEN = '1;

    // start of the no-read-while-write region
    localparam waddr_t NRWW_START = 14'h3800;

    // boot start per selector value, index = selector
    localparam waddr_t [NUM_SIZES-1:0] BOOT_START_TBL =
        {14'h3F00, 14'h3E00, 14'h3C00, 14'h3800};

    function automatic waddr_t boot_start(input logic [SEL_W-1:0] sel);
        return BOOT_START_TBL[sel];
    endfunction

    function automatic section_e addr_section(input waddr_t a,
                                              input logic [SEL_W-1:0] sel);
        return (a >= boot_start(sel)) ? SEC_BOOT : SEC_APP;
    endfunction

    typedef struct packed {
        logic   valid;
        lockf_t app;
        lockf_t boot;
    } lock_cmd_t;
endpackage

// File: rtl/fp_region_decode.sv
module fp_region_decode
    import flashprot_pkg::*;
(
    input  waddr_t           addr,
    input  logic [SEL_W-1:0] sel,
    output section_e         sec
);
    always_comb begin
        sec = addr_section(addr, sel);
    end
endmodule

// File: rtl/fp_lock_bank.sv
module fp_lock_bank
    import flashprot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lock_cmd_t sw_cmd,
    input  lock_cmd_t pg_cmd,
    input  logic      erase,
    output lockf_t    lock_app,
    output lockf_t    lock_boot
);
    lockf_t sw_val [NUM_SEC];
    lockf_t pg_val [NUM_SEC];
    lockf_t lock_q [NUM_SEC];

    assign sw_val[SEC_APP]  = sw_cmd.app;
    assign sw_val[SEC_BOOT] = sw_cmd.boot;
    assign pg_val[SEC_APP]  = pg_cmd.app;
    assign pg_val[SEC_BOOT] = pg_cmd.boot;

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_field
        lockf_t mask;
        always_comb begin
            mask = LOCK_OPEN;
            if (sw_cmd.valid) mask = mask & sw_val[s];
            if (pg_cmd.valid) mask = mask & pg_val[s];
        end
        always_ff @(posedge clk) begin
            if (rst)        lock_q[s] <= LOCK_OPEN;
            else if (erase) lock_q[s] <= LOCK_OPEN;
            else            lock_q[s] <= lock_q[s] & mask;
        end
    end

    assign lock_app  = lock_q[SEC_APP];
    assign lock_boot = lock_q[SEC_BOOT];
endmodule

// File: rtl/fp_access_judge.sv
module fp_access_judge
    import flashprot_pkg::*;
(
    input  section_e tgt_sec,
    input  section_e exec_sec,
    input  lockf_t   lock_app,
    input  lockf_t   lock_boot,
    output logic     store_ok,
    output logic     load_ok
);
    lockf_t tgt_lock;
    always_comb begin
        tgt_lock = (tgt_sec == SEC_BOOT) ? lock_boot : lock_app;
        store_ok = tgt_lock[LK_WRITE];
        load_ok  = (tgt_sec == exec_sec) || tgt_lock[LK_XREAD];
    end
endmodule

// File: rtl/flashprot_unit.sv
module flashprot_unit
    import flashprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        boot_sel,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [13:0]       req_addr,
    input  logic [13:0]       exec_addr,
    input  logic [15:0]       rd_in,
    input  logic              sw_set_valid,
    input  logic [1:0]        sw_set_app,
    input  logic [1:0]        sw_set_boot,
    input  logic              pg_set_valid,
    input  logic [1:0]        pg_set_app,
    input  logic [1:0]        pg_set_boot,
    input  logic              chip_erase,
    output logic              req_allow,
    output logic              req_section,
    output logic              req_in_rww,
    output logic              wr_en,
    output logic [15:0]       rd_out,
    output logic              viol,
    output logic [1:0]        lock_app,
    output logic [1:0]        lock_boot
);
    localparam int N_DEC = 2;

    waddr_t    dec_addr [N_DEC];
    section_e  dec_sec  [N_DEC];
    lock_cmd_t sw_cmd, pg_cmd;
    logic      store_ok, load_ok;
    logic      viol_q;

    assign dec_addr[0] = req_addr;
    assign dec_addr[1] = exec_addr;

    for (genvar d = 0; d < N_DEC; d++) begin : g_dec
        fp_region_decode u_dec (
            .addr (dec_addr[d]),
            .sel  (boot_sel),
            .sec  (dec_sec[d])
        );
    end

    assign sw_cmd = '{valid: sw_set_valid, app: sw_set_app, boot: sw_set_boot};
    assign pg_cmd = '{valid: pg_set_valid, app: pg_set_app, boot: pg_set_boot};

    fp_lock_bank u_locks (
        .clk       (clk),
        .rst       (rst),
        .sw_cmd    (sw_cmd),
        .pg_cmd    (pg_cmd),
        .erase     (chip_erase),
        .lock_app  (lock_app),
        .lock_boot (lock_boot)
    );

    fp_access_judge u_judge (
        .tgt_sec   (dec_sec[0]),
        .exec_sec  (dec_sec[1]),
        .lock_app  (lock_app),
        .lock_boot (lock_boot),
        .store_ok  (store_ok),
        .load_ok   (load_ok)
    );

    always_comb begin
        req_section = (dec_sec[0] == SEC_BOOT);
        req_in_rww  = (req_addr < NRWW_START);
        req_allow   = req_valid && (req_store ? store_ok : load_ok);
        wr_en       = req_valid && req_store && store_ok;
        rd_out      = (req_valid && !req_store && load_ok) ? rd_in : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= req_valid && req_store && !store_ok;
    end
    assign viol = viol_q;
endmodule

// File: rtl/flashprot_checker.sv
module flashprot_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_store,
    input logic        req_allow,
    input logic        wr_en,
    input logic [15:0] rd_out,
    input logic        viol,
    input logic        chip_erase,
    input logic [1:0]  lock_app,
    input logic [1:0]  lock_boot
);
    assert_wr_gated_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (req_valid && req_store && req_allow));

    assert_viol_cause_R7: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(req_valid && req_store && !req_allow));

    assert_no_raise_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(chip_erase) |->
            ((lock_app & ~$past(lock_app)) == 2'b00 &&
             (lock_boot & ~$past(lock_boot)) == 2'b00));

    assert_erase_open_R4: assert property (@(posedge clk) disable iff (rst)
        chip_erase |=> (lock_app == 2'b11 && lock_boot == 2'b11));

    assert_denied_load_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store && !req_allow) |-> (rd_out == 16'h0000));
endmodule

bind flashprot_unit flashprot_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_allow  (req_allow),
    .wr_en      (wr_en),
    .rd_out     (rd_out),
    .viol       (viol),
    .chip_erase (chip_erase),
    .lock_app   (lock_app),
    .lock_boot  (lock_boot)
);

// File: tb/sim_flashprot_unit.sv
`timescale 1ns/1ps
module sim_flashprot_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  boot_sel;
    logic        req_valid, req_store;
    logic [13:0] req_addr, exec_addr;
    logic [15:0] rd_in;
    logic        sw_set_valid, pg_set_valid, chip_erase;
    logic [1:0]  sw_set_app, sw_set_boot, pg_set_app, pg_set_boot;
    logic        req_allow, req_section, req_in_rww, wr_en, viol;
    logic [15:0] rd_out;
    logic [1:0]  lock_app, lock_boot;

    int total = 0;
    int bad = 0;
    logic [1:0] m_app, m_boot;
    logic       m_viol_next;

    always #2 clk = ~clk;

    flashprot_unit u0 (.*);

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [13:0] exp_start(input logic [1:0] s);
        case (s)
            2'd3: return 14'h3F00;
            2'd2: return 14'h3E00;
            2'd1: return 14'h3C00;
            default: return 14'h3800;
        endcase
    endfunction

    function automatic logic exp_sec(input logic [13:0] a, input logic [1:0] s);
        return a >= exp_start(s);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_store = 0; req_addr = 0; exec_addr = 0; rd_in = 0;
        sw_set_valid = 0; sw_set_app = 2'b11; sw_set_boot = 2'b11;
        pg_set_valid = 0; pg_set_app = 2'b11; pg_set_boot = 2'b11;
        chip_erase = 0; boot_sel = 2'b11;
    endtask

    // inputs are already driven (after a negedge); checks comb, clocks, checks state
    task automatic step();
        logic tsec, esec;
        logic [1:0] tl;
        logic st_ok, ld_ok, allow;
        logic [1:0] ma, mb;
        #1;
        tsec  = exp_sec(req_addr, boot_sel);
        esec  = exp_sec(exec_addr, boot_sel);
        tl    = tsec ? m_boot : m_app;
        st_ok = tl[0];
        ld_ok = (tsec == esec) || tl[1];
        allow = req_valid && (req_store ? st_ok : ld_ok);
        check("R1 section", {31'd0, req_section}, {31'd0, tsec});
        check("R2 rww", {31'd0, req_in_rww}, {31'd0, req_addr < 14'h3800});
        check("R5 allow", {31'd0, req_allow}, {31'd0, allow});
        check("R6 wr_en", {31'd0, wr_en}, {31'd0, req_valid && req_store && st_ok});
        check("R8 rd_out", {16'd0, rd_out},
              {16'd0, (req_valid && !req_store && ld_ok) ? rd_in : 16'h0});
        m_viol_next = req_valid && req_store && !st_ok;
        ma = 2'b11; mb = 2'b11;
        if (sw_set_valid) begin ma &= sw_set_app; mb &= sw_set_boot; end
        if (pg_set_valid) begin ma &= pg_set_app; mb &= pg_set_boot; end
        if (chip_erase) begin m_app = 2'b11; m_boot = 2'b11; end
        else begin m_app &= ma; m_boot &= mb; end
        @(posedge clk); #1;
        check("R7 viol", {31'd0, viol}, {31'd0, m_viol_next});
        check("R3 R4 R10 lock_app", {30'd0, lock_app}, {30'd0, m_app});
        check("R3 R4 R10 lock_boot", {30'd0, lock_boot}, {30'd0, m_boot});
        @(negedge clk);
    endtask

    function automatic logic [13:0] pick_addr(input logic [1:0] s);
        int r;
        r = $urandom_range(0, 3);
        if (r == 0) return exp_start(s) + 14'($urandom_range(0, 2)) - 14'd1;
        if (r == 1) return 14'h3800 + 14'($urandom_range(0, 1)) - 14'd1;
        return 14'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rst = 1;
        m_app = 2'b11; m_boot = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R9 reset lock_app", {30'd0, lock_app}, 32'd3);
        check("R9 reset lock_boot", {30'd0, lock_boot}, 32'd3);
        check("R9 reset viol", {31'd0, viol}, 32'd0);
        @(negedge clk);

        // R3: software clears write bit of application field
        idle_inputs(); sw_set_valid = 1; sw_set_app = 2'b10;
        step();
        // R5 R7: store into app denied from boot code
        idle_inputs(); req_valid = 1; req_store = 1; req_addr = 14'h0100; exec_addr = 14'h3F80;
        step();
        // R8: load in app from boot code still allowed (bit1 set)
        idle_inputs(); req_valid = 1; req_addr = 14'h0100; exec_addr = 14'h3F80; rd_in = 16'hBEEF;
        step();
        // R3: writing 11 must not restore
        idle_inputs(); sw_set_valid = 1;
        step();
        // R10: both sources in one cycle
        idle_inputs(); sw_set_valid = 1; sw_set_boot = 2'b10; pg_set_valid = 1; pg_set_boot = 2'b01;
        step();
        // R5: boot field 00 -> cross read from app denied, same-section read allowed
        idle_inputs(); req_valid = 1; req_addr = 14'h3F10; exec_addr = 14'h0010; rd_in = 16'h1234;
        step();
        idle_inputs(); req_valid = 1; req_addr = 14'h3F10; exec_addr = 14'h3F20; rd_in = 16'h5678;
        step();
        // R4: erase beats simultaneous set from both sources, with a store in flight
        idle_inputs(); chip_erase = 1; sw_set_valid = 1; sw_set_app = 2'b00; sw_set_boot = 2'b00;
        pg_set_valid = 1; pg_set_app = 2'b00; pg_set_boot = 2'b00;
        req_valid = 1; req_store = 1; req_addr = 14'h3F00;
        step();
        // R1 R2: boundaries for each selector
        for (int s = 0; s < 4; s++) begin
            idle_inputs(); boot_sel = 2'(s); req_valid = 1; req_addr = exp_start(2'(s)) - 14'd1;
            step();
            idle_inputs(); boot_sel = 2'(s); req_valid = 1; req_addr = exp_start(2'(s));
            step();
        end

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            idle_inputs();
            boot_sel     = 2'($urandom);
            req_valid    = ($urandom_range(0, 3) != 0);
            req_store    = 1'($urandom);
            req_addr     = pick_addr(boot_sel);
            exec_addr    = pick_addr(boot_sel);
            rd_in        = 16'($urandom);
            sw_set_valid = ($urandom_range(0, 15) == 0);
            sw_set_app   = 2'($urandom); sw_set_boot = 2'($urandom);
            pg_set_valid = ($urandom_range(0, 15) == 0);
            pg_set_app   = 2'($urandom); pg_set_boot = 2'($urandom);
            chip_erase   = ($urandom_range(0, 40) == 0);
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule